// File: doc/BRIEF.md
# Glitchless Gated Clock Divider

This block produces a slower clock from a master clock. It divides the master clock by a programmable period and drives the result onto one registered output. An enable input, which may be asynchronous, gates that output without glitches. The enable first passes through a chain of synchronizer flops in the master clock domain. The gate then opens or closes only at points where no pulse would be cut short.

When the enable drops, the output is handled in one of two ways. If it is low, it is held low from that point on. If it is high, its high phase runs to its scheduled end, and the output is held low after that. Once the gate has closed, the period counter is held at zero. Each reopening therefore starts a fresh high phase a fixed number of master cycles after the enable rises. A status output reports that the gate is fully closed.

Top module: `glitchless_clkdiv`

## Requirements
- R1: While reset is high, and at the first sample after it, `clk_div_out` is 0 and `gate_closed` is 1.
- R2: While the gate is open with an effective period N (N >= 2), the output repeats with a period of N master cycles. It is high for ceil(N/2) cycles and then low for floor(N/2) cycles, so an even N gives 50% duty.
- R3: `div_val` values 0 and 1 are treated as a period of 2, so the output toggles every master cycle.
- R4: If `en_in` rises between two master edges, the output goes high on the third rising edge that follows. The counter restarts at the beginning of a high phase, so the phase relative to the enable release is always the same.
- R5: If the output is low when the synchronized enable is first seen low, it stays low from then on and never rises again until the enable returns.
- R6: If the output is high when the synchronized enable is first seen low, that high phase keeps its full ceil(N/2) length before the output is held low.
- R7: `gate_closed` rises on the same edge at which the output is forced low or its final high phase ends. While `gate_closed` is 1, the output is 0.
- R8: A new `div_val` takes effect only at the wrap of the period counter, or while the gate is closed. The period that is in progress finishes with the value it started with.
- R9: If the enable comes back before a pending closure takes place, the output continues its current waveform with no extra edge and no closure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| en_in | input | 1 | Gate enable, may be asynchronous |
| div_val | input | DIV_W (10) | Requested division period |
| clk_div_out | output | 1 | Registered divided clock |
| gate_closed | output | 1 | Output low and counter held |

## Verification
The bench drops the enable in the middle of a high phase and measures the pulse length. A design that truncates the pulse would return a high count shorter than ceil(N/2). It also drops the enable during a low phase, just before a wrap would raise the output. A design that decides too late would let out one stray high pulse there. The bench changes the period partway through a period: an early load would shorten the running period, and a missed load would keep the old period. A short low blip on the enable during a long high phase catches a design that closes the gate and then reopens with a phase jump, and random traffic compared with a cycle model covers odd periods and periods of 0 and 1.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  typedef enum logic {
    GATE_SHUT = 1'b0,
    GATE_OPEN = 1'b1
  } gate_state_e;
endpackage

// File: rtl/gcd_sync.sv
module gcd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[s] <= 1'b0;
          else     chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

  initial begin
    a_r4_stage_count: assert (STAGES >= 2);
  end
endmodule

// File: rtl/gcd_counter.sv
module gcd_counter #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [DIV_W-1:0] div_val,
  output logic [DIV_W-1:0] cnt_q,
  output logic [DIV_W-1:0] per_q,
  output logic             wrap,
  output logic             adv_hi
);
  localparam logic [DIV_W-1:0] MIN_PER = DIV_W'(2);

  logic [DIV_W-1:0] per_eff;
  logic [DIV_W-1:0] cnt_adv;
  logic [DIV_W-1:0] per_adv;
  logic [DIV_W:0]   half_adv;

  always_comb begin
    per_eff  = (div_val < MIN_PER) ? MIN_PER : div_val;
    wrap     = (cnt_q == per_q - DIV_W'(1));
    cnt_adv  = wrap ? '0 : cnt_q + DIV_W'(1);
    per_adv  = wrap ? per_eff : per_q;
    half_adv = ({1'b0, per_adv} + (DIV_W+1)'(1)) >> 1;
    adv_hi   = ({1'b0, cnt_adv} < half_adv);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      per_q <= MIN_PER;
    end else if (clear) begin
      cnt_q <= '0;
      per_q <= per_eff;
    end else begin
      cnt_q <= cnt_adv;
      per_q <= per_adv;
    end
  end

  a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    cnt_q < per_q);
  a_r3_min_period: assert property (@(posedge clk) disable iff (rst)
    per_q >= MIN_PER);
  a_r8_period_held: assert property (@(posedge clk) disable iff (rst)
    (!$past(clear) && !$past(wrap)) |-> $stable(per_q));
endmodule

// File: rtl/gcd_gate.sv
module gcd_gate
  import gcd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en_sync,
  input  logic adv_hi,
  output logic clear,
  output logic out_q,
  output logic closed_q
);
  gate_state_e state_q;
  logic        closing;

  always_comb begin
    closing = (state_q == GATE_OPEN) && !en_sync && !(out_q && adv_hi);
    clear   = (state_q == GATE_SHUT) || closing;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= GATE_SHUT;
      out_q   <= 1'b0;
    end else begin
      case (state_q)
        GATE_SHUT: begin
          if (en_sync) begin
            state_q <= GATE_OPEN;
            out_q   <= 1'b1;
          end else begin
            out_q   <= 1'b0;
          end
        end
        default: begin
          if (closing) begin
            state_q <= GATE_SHUT;
            out_q   <= 1'b0;
          end else begin
            out_q   <= adv_hi;
          end
        end
      endcase
    end
  end

  assign closed_q = (state_q == GATE_SHUT);

  a_r7_closed_low: assert property (@(posedge clk) disable iff (rst)
    closed_q |-> !out_q);
  a_r5_shut_no_rise: assert property (@(posedge clk) disable iff (rst)
    (closed_q && !en_sync) |=> !out_q);
  a_r4_open_high: assert property (@(posedge clk) disable iff (rst)
    $fell(closed_q) |-> out_q);
endmodule

// File: rtl/glitchless_clkdiv.sv
module glitchless_clkdiv #(
  parameter int DIV_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_in,
  input  logic [DIV_W-1:0] div_val,
  output logic             clk_div_out,
  output logic             gate_closed
);
  logic             en_sync;
  logic             clear;
  logic             wrap;
  logic             adv_hi;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] per_q;
  logic [DIV_W:0]   cur_half;

  gcd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (en_in),
    .q   (en_sync)
  );

  gcd_counter #(.DIV_W(DIV_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clear   (clear),
    .div_val (div_val),
    .cnt_q   (cnt_q),
    .per_q   (per_q),
    .wrap    (wrap),
    .adv_hi  (adv_hi)
  );

  gcd_gate u_gate (
    .clk      (clk),
    .rst      (rst),
    .en_sync  (en_sync),
    .adv_hi   (adv_hi),
    .clear    (clear),
    .out_q    (clk_div_out),
    .closed_q (gate_closed)
  );

  assign cur_half = ({1'b0, per_q} + (DIV_W+1)'(1)) >> 1;

  a_r6_full_high: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_div_out) |-> ({1'b0, $past(cnt_q)} == $past(cur_half) - (DIV_W+1)'(1)));
  a_r4_restart_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_closed) |-> (cnt_q == '0));
endmodule

// File: tb/glitchless_clkdiv_bench.sv
module glitchless_clkdiv_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_in = 1'b0;
  logic [9:0] div_val = 10'd6;
  logic       clk_div_out;
  logic       gate_closed;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  glitchless_clkdiv u_glitchless_clkdiv (
    .clk (clk), .rst (rst), .en_in (en_in), .div_val (div_val),
    .clk_div_out (clk_div_out), .gate_closed (gate_closed)
  );

  function automatic int eff_per(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic int high_len(input int n);
    return (n + 1) / 2;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Cycle model built from the requirements
  logic m_s1, m_s2, m_open, m_out;
  int   m_cnt, m_per;
  always @(posedge clk) begin
    int acnt, aper;
    bit ahi, wr;
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_open <= 0; m_out <= 0; m_cnt <= 0; m_per <= 2;
    end else begin
      m_s1 <= en_in;
      m_s2 <= m_s1;
      wr   = (m_cnt == m_per - 1);
      acnt = wr ? 0 : m_cnt + 1;
      aper = wr ? eff_per(div_val) : m_per;
      ahi  = acnt < high_len(aper);
      if (!m_open) begin
        m_cnt <= 0; m_per <= eff_per(div_val);
        m_open <= m_s2; m_out <= m_s2;
      end else if (!m_s2 && !(m_out && ahi)) begin
        m_open <= 0; m_out <= 0; m_cnt <= 0; m_per <= eff_per(div_val);
      end else begin
        m_cnt <= acnt; m_per <= aper; m_out <= ahi;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 model output", int'(clk_div_out), int'(m_out));
      chk("R7 model closed", int'(gate_closed), int'(!m_open));
    end
  end

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    done = 1'b1;
    summary();
    $finish;
  end

  task automatic wait_rise(output int waited);
    waited = 0;
    while (!clk_div_out && waited < 5000) begin @(negedge clk); waited++; end
  endtask

  task automatic measure(output int hi, output int lo);
    hi = 0; lo = 0;
    while (clk_div_out && hi < 5000) begin hi++; @(negedge clk); end
    while (!clk_div_out && lo < 5000) begin lo++; @(negedge clk); end
  endtask

  initial begin
    int h, l, w, rises;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk("R1 reset out", int'(clk_div_out), 0);
    chk("R1 reset closed", int'(gate_closed), 1);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset out", int'(clk_div_out), 0);
    chk("R1 after reset closed", int'(gate_closed), 1);

    // R4 latency from enable release
    #1 en_in = 1'b1;
    @(negedge clk); chk("R4 edge1 low", int'(clk_div_out), 0);
    @(negedge clk); chk("R4 edge2 low", int'(clk_div_out), 0);
    @(negedge clk); chk("R4 edge3 high", int'(clk_div_out), 1);
    measure(h, l);
    chk("R2 even high", h, 3); chk("R2 even low", l, 3);

    // R8 change mid-period
    #1 div_val = 10'd7;
    measure(h, l);
    chk("R8 old period high", h, 3); chk("R8 old period low", l, 3);
    measure(h, l);
    chk("R2 odd high", h, 4); chk("R2 odd low", l, 3);

    // R6 disable during high phase
    #1 en_in = 1'b0;
    h = 0;
    while (clk_div_out && h < 100) begin h++; @(negedge clk); end
    chk("R6 full high kept", h, 4);
    chk("R7 closed after fall", int'(gate_closed), 1);
    rises = 0;
    repeat (30) begin @(negedge clk); if (clk_div_out) rises++; end
    chk("R5 held low", rises, 0);

    // R3 periods 0 and 1
    #1 div_val = 10'd0; en_in = 1'b1;
    wait_rise(w);
    chk("R4 reopen latency", w, 3);
    measure(h, l);
    chk("R3 zero high", h, 1); chk("R3 zero low", l, 1);
    #1 div_val = 10'd1;
    measure(h, l);
    measure(h, l);
    chk("R3 one high", h, 1); chk("R3 one low", l, 1);

    // R5 disable during low phase
    #1 div_val = 10'd10;
    measure(h, l);
    repeat (5) @(negedge clk);
    chk("R5 in low phase", int'(clk_div_out), 0);
    #1 en_in = 1'b0;
    rises = 0;
    repeat (40) begin @(negedge clk); if (clk_div_out) rises++; end
    chk("R5 no rise after low disable", rises, 0);
    chk("R7 closed after low disable", int'(gate_closed), 1);

    // R9 short enable blip during high phase
    #1 div_val = 10'd20; en_in = 1'b1;
    wait_rise(w);
    for (int i = 0; i < 30; i++) begin
      chk("R9 waveform kept", int'(clk_div_out), (i < 10 || i >= 20) ? 1 : 0);
      chk("R9 gate stays open", int'(gate_closed), 0);
      if (i == 1) #1 en_in = 1'b0;
      if (i == 3) #1 en_in = 1'b1;
      @(negedge clk);
    end

    // Random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      #1;
      if ($urandom % 40 == 0) en_in = ~en_in;
      if ($urandom % 70 == 0) div_val = 10'($urandom % 13);
    end
    en_in = 1'b0;
    repeat (40) @(negedge clk);
    chk("R7 final closed", int'(gate_closed), 1);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule